// File: doc/BRIEF.md
# MDIO Management Master

This block turns one management request at a time into a serial management frame on the MDC clock and the bidirectional MDIO data line toward a PHY. A request carries a 2-bit opcode and a 26-bit word. The upper 10 bits of that word hold the address: a 5-bit PHY address followed by a 5-bit register address. The lower 16 bits hold the write data. The requester raises its valid line and keeps it high for a window of about 31 system clocks. The block acts once, on the rising edge of that line.

The block builds MDC from the system clock. The divisor comes from bits [22:16] of a 32-bit configuration word, which resets to 0x00100000 in the requester. Output bits are launched when MDC falls. On a read, the block releases the line from the turnaround field onward and samples the PHY when MDC rises. At the end of every transaction, read or write, the block pulses a data-valid output for two system clocks. The falling edge of that pulse tells the requester that the transaction is finished.

Top module: `mdio_master`

## Requirements
- R1: Right after asynchronous reset, `mdc` is 1, `mdioOe` is 0, `rdValid` is 0 and `rdData` is 0.
- R2: A write (any opcode other than 2'b10, for example 2'b01) sends 64 bits, most significant bit first, with `mdioOe` high for every bit. The bits are: 32 ones, then 2'b01, then the opcode, then the 10-bit address from `reqWord[25:16]`, then turnaround 2'b10, then the data from `reqWord[15:0]`.
- R3: A read (opcode 2'b10) drives frame bits 0 to 45 as in R2 and holds `mdioOe` low for bits 46 to 63. It samples `mdioIn` on each rising `mdc` edge of bits 48 to 63, most significant bit first. It presents the 16 sampled bits on `rdData`, which changes only as `rdValid` rises.
- R4: One `mdc` period lasts 2×(D+1) system clocks. D is `cfgWord[22:16]`, sampled when the request is accepted. The value 0x00100000 gives 34 clocks.
- R5: `mdioOut` changes only on the clock edge where `mdc` falls.
- R6: A request is accepted only on a rising edge of `reqValid` while the block is idle. Keeping `reqValid` high starts no second frame. A rising edge during a transaction is ignored.
- R7: After the last frame bit of every transaction, `rdValid` is high for exactly 2 system clocks. During that time `mdc` is 1 and `mdioOe` is 0.
- R8: When no transaction is running, `mdc` is held at 1 and `mdioOe` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid, held high for a window |
| reqOpcode | input | 2 | 2'b10 read, 2'b01 write |
| reqWord | input | 26 | Address in [25:16], write data in [15:0] |
| cfgWord | input | 32 | Configuration word; [22:16] is the MDC divisor |
| mdioIn | input | 1 | Data sensed on the MDIO line |
| mdc | output | 1 | Management clock toward the PHY |
| mdioOut | output | 1 | Data driven onto the MDIO line |
| mdioOe | output | 1 | Drive enable for MDIO, 1 = driving |
| rdData | output | 16 | Data captured by the last read |
| rdValid | output | 1 | End-of-transaction pulse, 2 clocks long |

## Verification
The assertions check on every cycle:
- that `mdioOut` moves only together with a falling `mdc` (R5);
- that the end pulse lasts exactly two clocks, with `mdc` high and the line released (R7);
- that `rdData` changes only as that pulse starts (R3).

Some behaviour shows only in the bench's scenarios. A scoreboard checks the bit content of each frame, the drive-enable pattern of reads and the value a PHY model returns. It also measures the `mdc` period against the divisor, including a divisor change in the middle of a frame. Further scenarios hold `reqValid` high past the end of a frame and raise it again during a transaction; these show that no frame is started twice.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [1:0] OPC_READ = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new frame
    logic shift;   // launch next bit (mdc falling)
    logic drive;   // drive enable for the bit being launched
    logic sample;  // capture mdioIn (mdc rising, read data field)
    logic finish;  // last rising edge of the frame
    logic isRead;  // current transaction is a read
  } ctrlStrobes_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] divIn,
  output logic             mdc,
  output logic             fallTick,
  output logic             riseTick
);
  logic [DIV_W-1:0] divHeld;
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (cnt == divHeld);
  assign fallTick = tick && mdc;
  assign riseTick = tick && !mdc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divHeld <= '0;
      cnt     <= '0;
      mdc     <= 1'b1;
    end else begin
      if (start) divHeld <= divIn;
      if (!run) begin
        cnt <= '0;
        mdc <= 1'b1;
      end else if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int DATA_W     = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqOpcode,
  input  logic         fallTick,
  input  logic         riseTick,
  output ctrlStrobes_t strobes,
  output logic         run,
  output logic         rdValid
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT    = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] RELEASE_IDX = CNT_W'(FRAME_BITS - DATA_W - 2);
  localparam logic [CNT_W-1:0] DATA_IDX    = CNT_W'(FRAME_BITS - DATA_W);

  ctrlState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             holdCnt;
  logic             reqValidD;
  logic             isRead;
  logic             accept;

  assign accept  = (state == ST_IDLE) && reqValid && !reqValidD;
  assign run     = (state == ST_RUN);
  assign rdValid = (state == ST_DONE);

  always_comb begin
    strobes        = '0;
    strobes.load   = accept;
    strobes.shift  = fallTick;
    strobes.drive  = !(isRead && bitCnt >= RELEASE_IDX);
    strobes.sample = riseTick && isRead && (bitCnt > DATA_IDX);
    strobes.finish = riseTick && (bitCnt == LAST_CNT);
    strobes.isRead = isRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      holdCnt   <= 1'b0;
      reqValidD <= 1'b0;
      isRead    <= 1'b0;
    end else begin
      reqValidD <= reqValid;
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_RUN;
          bitCnt <= '0;
          isRead <= (reqOpcode == OPC_READ);
        end
        ST_RUN: begin
          if (fallTick) bitCnt <= bitCnt + 1'b1;
          if (strobes.finish) begin
            state   <= ST_DONE;
            holdCnt <= 1'b0;
          end
        end
        ST_DONE: begin
          if (holdCnt) state <= ST_IDLE;
          holdCnt <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [1:0]               reqOpcode,
  input  logic [ADDR_W+DATA_W-1:0] reqWord,
  input  logic                     mdioIn,
  output logic                     mdioOut,
  output logic                     mdioOe,
  output logic [DATA_W-1:0]        rdData
);
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + ADDR_W + 2 + DATA_W;

  logic [FRAME_BITS-1:0] shReg;
  logic [DATA_W-1:0]     rdShift;
  logic [FRAME_BITS-1:0] frameWord;

  assign frameWord = {{PRE_BITS{1'b1}}, 2'b01, reqOpcode,
                      reqWord[DATA_W +: ADDR_W], 2'b10, reqWord[DATA_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
      rdShift <= '0;
      rdData  <= '0;
    end else begin
      if (strobes.load) begin
        shReg <= frameWord;
      end else if (strobes.shift) begin
        mdioOut <= shReg[FRAME_BITS-1];
        mdioOe  <= strobes.drive;
        shReg   <= shReg << 1;
      end
      if (strobes.sample) rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (strobes.finish) begin
        mdioOe <= 1'b0;
        if (strobes.isRead) rdData <= {rdShift[DATA_W-2:0], mdioIn};
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int CFG_W    = 32,
  parameter int DIV_W    = 7,
  parameter int DIV_LSB  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [1:0]               reqOpcode,
  input  logic [ADDR_W+DATA_W-1:0] reqWord,
  input  logic [CFG_W-1:0]         cfgWord,
  input  logic                     mdioIn,
  output logic                     mdc,
  output logic                     mdioOut,
  output logic                     mdioOe,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + ADDR_W + 2 + DATA_W;

  ctrlStrobes_t strobes;
  logic         run;
  logic         fallTick;
  logic         riseTick;
  logic         unusedCfg;

  assign unusedCfg = ^cfgWord;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rstN(rstN), .start(strobes.load), .run(run),
    .divIn(cfgWord[DIV_LSB +: DIV_W]),
    .mdc(mdc), .fallTick(fallTick), .riseTick(riseTick)
  );

  mdio_ctrl #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .fallTick(fallTick), .riseTick(riseTick),
    .strobes(strobes), .run(run), .rdValid(rdValid)
  );

  mdio_datapath #(.PRE_BITS(PRE_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqOpcode(reqOpcode),
    .reqWord(reqWord), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid
);
  // R5: output data moves only with a falling mdc
  p_out_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> $fell(mdc));

  // R7: end pulse is at least two clocks long
  p_valid_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |=> rdValid);

  // R7: end pulse is no longer than two clocks
  p_valid_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid)) |=> !rdValid);

  // R7: during the end pulse mdc is high and the line is released
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (mdc && !mdioOe));

  // R3: read data changes only as the end pulse starts
  p_data_update_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $rose(rdValid));
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut),
  .mdioOe(mdioOe), .rdData(rdData), .rdValid(rdValid)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  typedef struct {
    logic [1:0]  op;
    logic [9:0]  addr;
    logic [15:0] data;
    logic [15:0] phyVal;
    int          period;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOpcode = 2'b00;
  logic [25:0] reqWord = '0;
  logic [31:0] cfgWord = 32'h0010_0000;
  logic        mdioIn = 1'b0;
  logic        mdc, mdioOut, mdioOe, rdValid;
  logic [15:0] rdData;

  int checks = 0;
  int fails = 0;
  int txDone = 0;
  int cyc = 0;
  item_t expQ[$];
  logic [15:0] phyVal = '0;

  always #10 clk = ~clk;  // 50 MHz

  mdio_master u_mdio_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .reqWord(reqWord), .cfgWord(cfgWord), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: PHY model plus scoreboard compare
  logic outBits[64];
  logic oeBits[64];
  int   bitIdx = 0;
  int   firstFall = 0;
  int   measPeriod = 0;
  int   vHigh = 0;
  int   edgeErr = 0;
  logic mdcPrev = 1'b1;
  logic outPrev = 1'b1;
  logic vPrev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (mdioOut !== outPrev && !(mdcPrev && !mdc)) edgeErr++;
      if (mdcPrev && !mdc) begin
        if (bitIdx < 64) begin
          outBits[bitIdx] = mdioOut;
          oeBits[bitIdx]  = mdioOe;
        end
        if (bitIdx == 0) firstFall = cyc;
        if (bitIdx == 1) measPeriod = cyc - firstFall;
        if (bitIdx >= 48 && bitIdx < 64) mdioIn = phyVal[63 - bitIdx];
        bitIdx++;
      end
      if (rdValid) vHigh++;
      if (vPrev && !rdValid) begin
        txDone++;
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected extra transaction", txDone, 0);
        end else begin
          item_t e;
          logic [63:0] ef;
          int errs;
          int oeErrs;
          bit rd;
          e = expQ.pop_front();
          ef = {32'hFFFF_FFFF, 2'b01, e.op, e.addr, 2'b10, e.data};
          rd = (e.op == 2'b10);
          errs = 0;
          oeErrs = 0;
          for (int i = 0; i < 64; i++) begin
            if (!rd || i < 46) begin
              if (outBits[i] !== ef[63 - i]) errs++;
            end
            if (oeBits[i] !== ((!rd || i < 46) ? 1'b1 : 1'b0)) oeErrs++;
          end
          check(bitIdx == 64, "R2", "bit count", bitIdx, 64);
          if (rd) begin
            check(errs == 0, "R3", "read header bit errors", errs, 0);
            check(oeErrs == 0, "R3", "read oe pattern errors", oeErrs, 0);
            check(rdData === e.phyVal, "R3", "read data", rdData, e.phyVal);
          end else begin
            check(errs == 0, "R2", "write frame bit errors", errs, 0);
            check(oeErrs == 0, "R2", "write oe errors", oeErrs, 0);
          end
          check(measPeriod == e.period, "R4", "mdc period", measPeriod, e.period);
          check(vHigh == 2, "R7", "rdValid length", vHigh, 2);
        end
        bitIdx = 0;
        vHigh = 0;
      end
    end
    mdcPrev = mdc;
    outPrev = mdioOut;
    vPrev = rdValid;
  end

  // driver: push expectation, then present the request
  task automatic doReq(input logic [1:0] op, input logic [9:0] addr,
                       input logic [15:0] data, input logic [15:0] pv,
                       input int div, input int hold);
    item_t e;
    int target;
    e.op = op; e.addr = addr; e.data = data; e.phyVal = pv;
    e.period = 2 * (div + 1);
    expQ.push_back(e);
    target = txDone + 1;
    @(negedge clk);
    cfgWord = 32'h0000_0000 | (32'(div) << 16);
    phyVal = pv;
    reqOpcode = op;
    reqWord = {addr, data};
    reqValid = 1'b1;
    repeat (hold) @(negedge clk);
    reqValid = 1'b0;
    while (txDone < target) @(negedge clk);
    repeat (3) @(negedge clk);
    check(mdc === 1'b1 && mdioOe === 1'b0, "R8", "idle mdc/oe", {mdc, mdioOe}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mdc === 1'b1 && mdioOe === 1'b0, "R1", "reset mdc/oe", {mdc, mdioOe}, 2'b10);
    check(rdValid === 1'b0 && rdData === 16'h0, "R1", "reset rdValid/rdData",
          {rdValid, rdData}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // default configuration divisor 16 -> 34-clock period (R4), write (R2)
    doReq(2'b01, 10'h2A5, 16'hBEEF, 16'h0000, 16, 31);
    // read with fastest divider (R3)
    doReq(2'b10, 10'h155, 16'h0000, 16'hA5C3, 0, 31);
    // write, all-ones address, LSB-only data (R2)
    doReq(2'b01, 10'h3FF, 16'h0001, 16'h0000, 3, 31);
    // read, data with only end bits set (R3)
    doReq(2'b10, 10'h001, 16'hFFFF, 16'h8001, 1, 31);

    // R4: divisor change during a frame does not affect it
    begin
      item_t e;
      int target;
      e.op = 2'b01; e.addr = 10'h0F0; e.data = 16'h1234; e.phyVal = 0; e.period = 6;
      expQ.push_back(e);
      target = txDone + 1;
      @(negedge clk);
      cfgWord = 32'h0002_0000;
      reqOpcode = 2'b01; reqWord = {10'h0F0, 16'h1234}; reqValid = 1'b1;
      repeat (2) @(negedge clk);
      cfgWord = 32'h0007_0000;
      repeat (29) @(negedge clk);
      reqValid = 1'b0;
      while (txDone < target) @(negedge clk);
      repeat (3) @(negedge clk);
    end

    // R6: valid held well past the end of the frame starts nothing more
    doReq(2'b01, 10'h0AA, 16'h5555, 16'h0000, 0, 300);
    repeat (200) @(negedge clk);
    check(txDone == 6 && bitIdx == 0, "R6", "held valid restarted", txDone, 6);

    // R6: a second rising edge during a busy frame is ignored
    begin
      item_t e;
      e.op = 2'b10; e.addr = 10'h3C3; e.data = 16'h0; e.phyVal = 16'h7E18; e.period = 2;
      expQ.push_back(e);
      @(negedge clk);
      cfgWord = 32'h0; phyVal = 16'h7E18;
      reqOpcode = 2'b10; reqWord = {10'h3C3, 16'h0}; reqValid = 1'b1;
      repeat (31) @(negedge clk);
      reqValid = 1'b0;
      repeat (20) @(negedge clk);
      reqValid = 1'b1;
      repeat (31) @(negedge clk);
      reqValid = 1'b0;
      while (txDone < 7) @(negedge clk);
      repeat (300) @(negedge clk);
      check(txDone == 7 && bitIdx == 0, "R6", "edge during busy restarted", txDone, 7);
    end

    check(edgeErr == 0, "R5", "mdioOut moved off a falling mdc", edgeErr, 0);
    check(expQ.size() == 0, "R6", "scoreboard leftovers", expQ.size(), 0);
    finishRun();
  end
endmodule